// File: doc/BRIEF.md
# Multibit Trie Route Lookup Engine

This block resolves the longest matching prefix for a 32-bit IPv4 destination address. The routing table is a hierarchical trie with a 4-bit stride, which avoids a flat table indexed by the whole address. Each trie node has sixteen slots. The slot visited at each level is selected by the next nibble of the address, starting at the most significant nibble. Each slot holds a route pointer, which is a next-hop identifier, and a child pointer to a node on the next level. In both fields the value zero means "none".

A lookup enters through a valid/ready handshake. The walker starts at node 0, which is the root. For each level it reads one slot from an internal synchronous node memory. Any non-zero route pointer it reads becomes the current best match, so when the walk finishes the best match is the deepest route seen. The walk stops on a zero child pointer or after eight levels. The result is then presented for one cycle. A single-entry write port loads the table before lookups are issued.

Top module: `lpm_trie_engine`

## Requirements
- R1: During reset and in the first cycle after it, `req_ready` is 1 and `rsp_valid` is 0. After reset every slot of every node reads as route 0 and child 0, so any lookup misses after one level.
- R2: Level L (counting from 0) uses address bits [31-4L : 28-4L] as the slot index. Level 0 reads node 0. Each later level reads the node named by the child pointer found at the level before it.
- R3: A slot with a non-zero route pointer replaces the current best match. The reported route is the route pointer of the deepest slot visited that had a non-zero route.
- R4: A slot whose child pointer is 0 ends the walk after that slot has been evaluated.
- R5: The walk visits at most 8 levels. The slot at level 7 ends the walk even when its child pointer is non-zero.
- R6: If no visited slot had a non-zero route, the response has `rsp_hit` = 0 and `rsp_route` = 0. Otherwise `rsp_hit` = 1.
- R7: When a walk visits k levels, `rsp_valid` goes high exactly 2k clock edges after the edge that accepted the request. It stays high for exactly one cycle.
- R8: `req_ready` is 0 from the edge that accepts a request until the response cycle has ended. A request presented during that time is ignored and produces no response.
- R9: A write with `wr_en` = 1 stores `wr_route` and `wr_child` into slot `wr_slot` of node `wr_node`. A later write to the same slot replaces the earlier value.
- R10: `req_ready` returns to 1 in the cycle right after the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle; a request is accepted on this edge |
| req_key | input | 32 | Destination address to look up |
| rsp_valid | output | 1 | One-cycle pulse marking the result |
| rsp_hit | output | 1 | A route was found |
| rsp_route | output | ROUTE_W (8) | Next-hop identifier of the longest match, 0 on a miss |
| wr_en | input | 1 | Write one table slot |
| wr_node | input | NODE_W (4) | Node index of the write |
| wr_slot | input | 4 | Slot within the node |
| wr_route | input | ROUTE_W (8) | Route pointer to store (0 = none) |
| wr_child | input | NODE_W (4) | Child node pointer to store (0 = none) |

## Verification
Faults in the level counter or the node register do not show up as a stuck output. They send the walk to the wrong slot, so the wrong route comes back, or they stop the walk early or late. The response then arrives a multiple of two cycles off its expected edge, and it does so within the same lookup. For that reason the bench checks the exact response edge of every lookup, as well as the route value. It also uses paths that differ only at the deepest level, and a chain that would keep going past the eighth level, so that errors in depth and in best-match retention become visible at the ports.

// File: rtl/lpm_trie_pkg.sv
package lpm_trie_pkg;

    localparam int KEY_W      = 32;
    localparam int STRIDE     = 4;
    localparam int SLOTS      = 1 << STRIDE;
    localparam int MAX_LEVELS = KEY_W / STRIDE;
    localparam int LVL_W      = $clog2(MAX_LEVELS);

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_READ,
        WK_EVAL,
        WK_DONE
    } walk_state_e;

    // Slot index for a given trie level, most significant nibble first.
    function automatic logic [STRIDE-1:0] key_nibble(
        input logic [KEY_W-1:0] key,
        input logic [LVL_W-1:0] lvl
    );
        logic [KEY_W-1:0] shifted;
        shifted = key << (STRIDE * int'(lvl));
        return shifted[KEY_W-1 -: STRIDE];
    endfunction

endpackage

// File: rtl/trie_node_ram.sv
module trie_node_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/trie_walker.sv
module trie_walker
    import lpm_trie_pkg::*;
#(
    parameter int ROUTE_W = 8,
    parameter int NODE_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [KEY_W-1:0]         req_key,
    output logic                     rd_en,
    output logic [NODE_W+STRIDE-1:0] rd_addr,
    input  logic [ROUTE_W+NODE_W-1:0] rd_data,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [ROUTE_W-1:0]       rsp_route
);
    localparam int DATA_W = ROUTE_W + NODE_W;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(MAX_LEVELS - 1);

    walk_state_e        state;
    logic [KEY_W-1:0]   key_q;
    logic [NODE_W-1:0]  node_q;
    logic [LVL_W-1:0]   lvl_q;
    logic [ROUTE_W-1:0] best_q;

    logic [ROUTE_W-1:0] ent_route;
    logic [NODE_W-1:0]  ent_child;
    logic               accept;
    logic               walk_end;

    assign ent_route = rd_data[DATA_W-1 -: ROUTE_W];
    assign ent_child = rd_data[NODE_W-1:0];

    assign req_ready = (state == WK_IDLE);
    assign accept    = req_valid && req_ready;
    assign rd_en     = (state == WK_READ);
    assign rd_addr   = {node_q, key_nibble(key_q, lvl_q)};
    assign walk_end  = (ent_child == '0) || (lvl_q == LAST_LVL);

    assign rsp_valid = (state == WK_DONE);
    assign rsp_route = best_q;
    assign rsp_hit   = (best_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WK_IDLE;
            key_q  <= '0;
            node_q <= '0;
            lvl_q  <= '0;
            best_q <= '0;
        end else begin
            unique case (state)
                WK_IDLE: begin
                    if (accept) begin
                        key_q  <= req_key;
                        node_q <= '0;
                        lvl_q  <= '0;
                        best_q <= '0;
                        state  <= WK_READ;
                    end
                end
                WK_READ: state <= WK_EVAL;
                WK_EVAL: begin
                    if (ent_route != '0) begin
                        best_q <= ent_route;
                    end
                    if (walk_end) begin
                        state <= WK_DONE;
                    end else begin
                        node_q <= ent_child;
                        lvl_q  <= lvl_q + 1'b1;
                        state  <= WK_READ;
                    end
                end
                WK_DONE: state <= WK_IDLE;
                default: state <= WK_IDLE;
            endcase
        end
    end

    // R7
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    ready_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> req_ready);

    // R2
    eval_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (state == WK_EVAL) |-> ($past(state) == WK_READ));

    // R5
    level_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == WK_READ && $past(state) == WK_EVAL) |->
            (lvl_q == LVL_W'($past(lvl_q) + 1'b1)));

endmodule

// File: rtl/lpm_trie_engine.sv
module lpm_trie_engine
    import lpm_trie_pkg::*;
#(
    parameter int ROUTE_W = 8,
    parameter int NODE_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [31:0]        req_key,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [ROUTE_W-1:0] rsp_route,
    input  logic               wr_en,
    input  logic [NODE_W-1:0]  wr_node,
    input  logic [3:0]         wr_slot,
    input  logic [ROUTE_W-1:0] wr_route,
    input  logic [NODE_W-1:0]  wr_child
);
    localparam int RAM_AW = NODE_W + STRIDE;
    localparam int RAM_DW = ROUTE_W + NODE_W;

    logic              rd_en;
    logic [RAM_AW-1:0] rd_addr;
    logic [RAM_DW-1:0] rd_data;

    trie_node_ram #(
        .ADDR_W (RAM_AW),
        .DATA_W (RAM_DW)
    ) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr ({wr_node, wr_slot}),
        .wdata ({wr_route, wr_child}),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    trie_walker #(
        .ROUTE_W (ROUTE_W),
        .NODE_W  (NODE_W)
    ) u_walk (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_key   (req_key),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_route (rsp_route)
    );

endmodule

// File: tb/lpm_trie_engine_bench.sv
module lpm_trie_engine_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_key;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [7:0]  rsp_route;
    logic        wr_en;
    logic [3:0]  wr_node;
    logic [3:0]  wr_slot;
    logic [7:0]  wr_route;
    logic [3:0]  wr_child;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    lpm_trie_engine u_lpm_trie_engine (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_key   (req_key),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_route (rsp_route),
        .wr_en     (wr_en),
        .wr_node   (wr_node),
        .wr_slot   (wr_slot),
        .wr_route  (wr_route),
        .wr_child  (wr_child)
    );

    localparam int NV = 8;
    localparam logic [31:0] V_KEY [NV] = '{
        32'h13fe2233, 32'h2abcdef0, 32'h50000000, 32'h13000000,
        32'h14000000, 32'h77777777, 32'h9a000000, 32'h13f00000};
    localparam logic        V_HIT [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [7:0]  V_ROUTE [NV] = '{
        8'h22, 8'h20, 8'h00, 8'h10, 8'h10, 8'h77, 8'h00, 8'h22};
    localparam int          V_EDGES [NV] = '{8, 2, 2, 6, 4, 16, 4, 8};

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_entry(input logic [3:0] node, input logic [3:0] slot,
                            input logic [7:0] route, input logic [3:0] child);
        @(negedge clk);
        wr_en = 1'b1; wr_node = node; wr_slot = slot; wr_route = route; wr_child = child;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] key, input logic exp_hit,
                          input logic [7:0] exp_route, input int exp_edges, input string tag);
        int n;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready before request", 32'(req_ready), 1);
        req_valid = 1'b1;
        req_key   = key;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 40) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        chk(n == exp_edges, {tag, " R7 response edge"}, 32'(n), 32'(exp_edges));
        chk(rsp_hit == exp_hit, {tag, " R6 hit flag"}, 32'(rsp_hit), 32'(exp_hit));
        chk(rsp_route == exp_route, {tag, " R3 route"}, 32'(rsp_route), 32'(exp_route));
        chk(req_ready == 1'b0, "R8 busy during response", 32'(req_ready), 0);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R7 one-cycle pulse", 32'(rsp_valid), 0);
        chk(req_ready == 1'b1, "R10 ready after response", 32'(req_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_key = '0;
        wr_en = 1'b0; wr_node = '0; wr_slot = '0; wr_route = '0; wr_child = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 no response in reset", 32'(rsp_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 0);

        // R1: empty table misses after one level
        lookup(32'h13fe2233, 1'b0, 8'h00, 2, "R1");

        // R9: load the table
        wr_entry(4'd0, 4'h1, 8'h10, 4'd1);
        wr_entry(4'd1, 4'h3, 8'h00, 4'd2);
        wr_entry(4'd2, 4'hf, 8'h22, 4'd3);
        wr_entry(4'd3, 4'he, 8'h00, 4'd0);
        wr_entry(4'd0, 4'h2, 8'h20, 4'd0);
        wr_entry(4'd0, 4'h5, 8'h00, 4'd0);
        wr_entry(4'd0, 4'h9, 8'h00, 4'd12);
        for (int lv = 0; lv < 8; lv++) begin
            wr_entry((lv == 0) ? 4'd0 : 4'(3 + lv), 4'h7,
                     (lv == 2) ? 8'h55 : (lv == 7) ? 8'h77 : 8'h00, 4'(4 + lv));
        end
        wr_entry(4'd11, 4'h7, 8'h99, 4'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            case (i)
                0: tag = "R2";
                1: tag = "R4";
                2: tag = "R6";
                5: tag = "R5";
                default: tag = "R3";
            endcase
            lookup(V_KEY[i], V_HIT[i], V_ROUTE[i], V_EDGES[i], tag);
        end

        // R9: overwrite a slot
        wr_entry(4'd0, 4'h2, 8'h2b, 4'd0);
        lookup(32'h2abcdef0, 1'b1, 8'h2b, 2, "R9");

        // R8: request while busy is ignored
        begin
            int pulses;
            int n;
            @(negedge clk);
            req_valid = 1'b1; req_key = 32'h77777777;
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            @(negedge clk);
            chk(req_ready == 1'b0, "R8 busy mid-walk", 32'(req_ready), 0);
            req_valid = 1'b1; req_key = 32'h2abcdef0;
            @(negedge clk);
            req_valid = 1'b0;
            pulses = 0;
            n = 2;
            for (int c = 0; c < 40; c++) begin
                if (rsp_valid) begin
                    pulses++;
                    chk(rsp_route == 8'h77, "R8 busy request ignored route", 32'(rsp_route), 32'h77);
                    chk(n == 16, "R8 response edge unaffected", 32'(n), 16);
                end
                @(negedge clk);
                n++;
            end
            chk(pulses == 1, "R8 single response", 32'(pulses), 1);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule